// File: doc/BRIEF.md
# Jitter-weighted earliest-deadline-first scheduler

This block chooses which of several per-flow output queues sends next. When a packet descriptor arrives, the block records the current time as the packet's entry time. It then gives the packet a deadline: the entry time plus the packet length scaled by a per-queue factor. The factor is the fixed-point reciprocal of the flow's rate multiplied by its weight. A flow that tolerates less delay and jitter is given a larger weight, which means a smaller factor and so earlier deadlines. The descriptor waits in that queue's FIFO.

Each dequeue request is answered one cycle later. The answer comes from the backlogged queue whose head has the earliest deadline. When head deadlines are equal, the queue that has built up more delay jitter is served. When the jitter values are also equal, the lowest queue index is served. Each queue keeps a running sum of the absolute change in queuing delay between consecutive departures. This sum is updated in the cycle the grant appears. The time base counts clock cycles from the release of reset. Payload storage and link framing sit outside the block.

Top module: `jwedf_sched`

## Requirements
- R1: After reset, deq_gnt_o and enq_drop_o are 0 and every queue is empty. Every per-queue scale resets to 65536 (1.0 in 16-bit fraction).
- R2: An accepted enqueue in cycle t gets entry time t, where t is the number of clock edges since reset release. Its deadline is t + ((len * scale) >> 16), using the scale the queue held in that cycle.
- R3: Each queue is a FIFO holding 16 descriptors. An enqueue to a full queue is discarded, and enq_drop_o pulses high in the following cycle.
- R4: A request in cycle t that finds any backlog gives a grant in cycle t+1. The grant carries the queue index, descriptor, length and deadline of the chosen head, and a delay equal to t minus the head's entry time.
- R5: Among backlogged queues, the head with the smallest deadline is served.
- R6: When the smallest deadline is shared, the queue with the larger jitter sum is served.
- R7: When both the deadline and the jitter sum are equal, the lowest queue index is served.
- R8: A queue's jitter sum starts at 0 and adds nothing on the queue's first departure. On each later departure it adds the absolute difference between this departure's delay and the previous one's. deq_jitter_o reports the sum after this update.
- R9: The block is work-conserving. A request always gives a grant when any queue holds a packet, and never gives one when all queues are empty.
- R10: A scale write (cfg_we_i) changes the deadlines of later enqueues to that queue only. Descriptors already stored keep their deadlines.
- R11: An enqueue that arrives in the same cycle as a request is not a candidate for that request. An enqueue to a full queue is dropped even when the same cycle's request pops that queue.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cfg_we_i | input | 1 | Scale write strobe |
| cfg_qid_i | input | 2 | Queue addressed by the scale write |
| cfg_scale_i | input | 20 | Reciprocal of rate times weight, 16 fraction bits |
| enq_valid_i | input | 1 | Enqueue strobe |
| enq_qid_i | input | 2 | Target queue |
| enq_len_i | input | 12 | Packet length |
| enq_desc_i | input | 8 | Packet descriptor |
| enq_drop_o | output | 1 | Pulse: previous cycle's enqueue hit a full queue |
| deq_req_i | input | 1 | Dequeue request |
| deq_gnt_o | output | 1 | Grant for the previous cycle's request |
| deq_qid_o | output | 2 | Served queue |
| deq_desc_o | output | 8 | Served descriptor |
| deq_len_o | output | 12 | Served length |
| deq_deadline_o | output | 24 | Served deadline |
| deq_delay_o | output | 24 | Queuing delay of the served packet |
| deq_jitter_o | output | 20 | Served queue's jitter sum after this departure |

## Verification
Enqueue and dequeue can land in the same cycle, and the same queue can be involved in both. The bench provokes this in several ways. It requests while enqueuing into an empty queue, which must give no grant. It requests while enqueuing into the queue being popped, which must not serve the new packet. It enqueues into a full queue while popping that same queue, which must still drop. A long run of mixed traffic with deliberately colliding enqueues and requests on four queues follows. Equal scales and short lengths make deadline ties, and therefore jitter and index tie-breaks, frequent. Each grant is judged against a model in the bench that tracks entry times, deadlines and jitter sums arithmetically.

// File: rtl/jwedf_pkg.sv
package jwedf_pkg;
  localparam int TIME_W  = 24;
  localparam int LEN_W   = 12;
  localparam int DESC_W  = 8;
  localparam int SCALE_W = 20;
  localparam int FRAC_W  = 16;
  localparam int JIT_W   = 20;
  localparam logic [SCALE_W-1:0] SCALE_ONE = SCALE_W'(1 << FRAC_W);

  typedef struct packed {
    logic [TIME_W-1:0] deadline;
    logic [TIME_W-1:0] entry;
    logic [LEN_W-1:0]  len;
    logic [DESC_W-1:0] desc;
  } entry_t;
endpackage

// File: rtl/jwedf_fifo.sv
module jwedf_fifo import jwedf_pkg::*; #(
  parameter int DEPTH = 16
) (
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   push_i,
  input  entry_t din_i,
  input  logic   pop_i,
  output entry_t head_o,
  output logic   nempty_o,
  output logic   full_o
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  entry_t mem [DEPTH];
  logic [PTR_W-1:0] wr_q, rd_q;
  logic [CNT_W-1:0] cnt_q;

  function automatic logic [PTR_W-1:0] nxt(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i) begin
    if (push_i) mem[wr_q] <= din_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (push_i) wr_q <= nxt(wr_q);
      if (pop_i)  rd_q <= nxt(rd_q);
      case ({push_i, pop_i})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  assign head_o   = mem[rd_q];
  assign nempty_o = (cnt_q != '0);
  assign full_o   = (cnt_q == CNT_W'(DEPTH));
endmodule

// File: rtl/jwedf_deadline.sv
module jwedf_deadline import jwedf_pkg::*; (
  input  logic [TIME_W-1:0]  now_i,
  input  logic [LEN_W-1:0]   len_i,
  input  logic [SCALE_W-1:0] scale_i,
  output logic [TIME_W-1:0]  deadline_o
);
  localparam int PROD_W = LEN_W + SCALE_W;

  logic [PROD_W-1:0] prod;
  logic [PROD_W-FRAC_W-1:0] offset;

  // multiply by reciprocal instead of dividing by rate*weight
  assign prod       = PROD_W'(len_i) * PROD_W'(scale_i);
  assign offset     = prod[PROD_W-1:FRAC_W];
  assign deadline_o = now_i + TIME_W'(offset);
endmodule

// File: rtl/jwedf_jitter.sv
module jwedf_jitter import jwedf_pkg::*; (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              upd_i,
  input  logic [TIME_W-1:0] delay_i,
  output logic [JIT_W-1:0]  jit_o,
  output logic [JIT_W-1:0]  jit_nxt_o
);
  localparam logic [TIME_W:0] JIT_MAX = (TIME_W+1)'({JIT_W{1'b1}});

  logic              seen_q;
  logic [TIME_W-1:0] last_q;
  logic [JIT_W-1:0]  acc_q;
  logic [TIME_W-1:0] diff;
  logic [TIME_W:0]   sum;

  assign diff = (delay_i >= last_q) ? delay_i - last_q : last_q - delay_i;
  assign sum  = {1'b0, diff} + (TIME_W+1)'(acc_q);

  always_comb begin
    jit_nxt_o = acc_q;
    if (upd_i && seen_q) jit_nxt_o = (sum > JIT_MAX) ? '1 : sum[JIT_W-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      seen_q <= 1'b0;
      last_q <= '0;
      acc_q  <= '0;
    end else if (upd_i) begin
      seen_q <= 1'b1;
      last_q <= delay_i;
      acc_q  <= jit_nxt_o;
    end
  end

  assign jit_o = acc_q;
endmodule

// File: rtl/jwedf_pick.sv
module jwedf_pick import jwedf_pkg::*; #(
  parameter int NUM_Q = 4,
  localparam int QID_W = (NUM_Q > 1) ? $clog2(NUM_Q) : 1
) (
  input  logic [NUM_Q-1:0]             nempty_i,
  input  logic [NUM_Q-1:0][TIME_W-1:0] dl_i,
  input  logic [NUM_Q-1:0][JIT_W-1:0]  jit_i,
  output logic                         any_o,
  output logic [QID_W-1:0]             sel_o
);
  logic [TIME_W-1:0] best_dl;
  logic [JIT_W-1:0]  best_jit;

  // ascending scan with strict compares: lowest index wins full ties
  always_comb begin
    any_o    = 1'b0;
    sel_o    = '0;
    best_dl  = '0;
    best_jit = '0;
    for (int i = 0; i < NUM_Q; i++) begin
      if (nempty_i[i]) begin
        if (!any_o || (dl_i[i] < best_dl) ||
            ((dl_i[i] == best_dl) && (jit_i[i] > best_jit))) begin
          any_o    = 1'b1;
          sel_o    = QID_W'(i);
          best_dl  = dl_i[i];
          best_jit = jit_i[i];
        end
      end
    end
  end
endmodule

// File: rtl/jwedf_sched.sv
module jwedf_sched import jwedf_pkg::*; #(
  parameter int NUM_Q = 4,
  parameter int DEPTH = 16,
  localparam int QID_W = (NUM_Q > 1) ? $clog2(NUM_Q) : 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               cfg_we_i,
  input  logic [QID_W-1:0]   cfg_qid_i,
  input  logic [SCALE_W-1:0] cfg_scale_i,
  input  logic               enq_valid_i,
  input  logic [QID_W-1:0]   enq_qid_i,
  input  logic [LEN_W-1:0]   enq_len_i,
  input  logic [DESC_W-1:0]  enq_desc_i,
  output logic               enq_drop_o,
  input  logic               deq_req_i,
  output logic               deq_gnt_o,
  output logic [QID_W-1:0]   deq_qid_o,
  output logic [DESC_W-1:0]  deq_desc_o,
  output logic [LEN_W-1:0]   deq_len_o,
  output logic [TIME_W-1:0]  deq_deadline_o,
  output logic [TIME_W-1:0]  deq_delay_o,
  output logic [JIT_W-1:0]   deq_jitter_o
);
  logic [TIME_W-1:0]  now_q;
  logic [SCALE_W-1:0] scale_q [NUM_Q];
  logic [TIME_W-1:0]  enq_dl;
  entry_t             enq_entry;

  logic [NUM_Q-1:0]             q_nempty, q_full, push, pop;
  entry_t                       head [NUM_Q];
  logic [NUM_Q-1:0][TIME_W-1:0] head_dl, head_delay;
  logic [NUM_Q-1:0][JIT_W-1:0]  jit_val, jit_nxt;
  logic                         any;
  logic [QID_W-1:0]             sel;
  logic                         serve;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      now_q <= '0;
      for (int i = 0; i < NUM_Q; i++) scale_q[i] <= SCALE_ONE;
    end else begin
      now_q <= now_q + 1'b1;
      if (cfg_we_i) scale_q[cfg_qid_i] <= cfg_scale_i;
    end
  end

  jwedf_deadline u_deadline (
    .now_i     (now_q),
    .len_i     (enq_len_i),
    .scale_i   (scale_q[enq_qid_i]),
    .deadline_o(enq_dl)
  );

  assign enq_entry = '{deadline: enq_dl, entry: now_q, len: enq_len_i, desc: enq_desc_i};

  jwedf_pick #(.NUM_Q(NUM_Q)) u_pick (
    .nempty_i(q_nempty),
    .dl_i    (head_dl),
    .jit_i   (jit_val),
    .any_o   (any),
    .sel_o   (sel)
  );

  assign serve = deq_req_i && any;

  for (genvar q = 0; q < NUM_Q; q++) begin : g_q
    assign push[q] = enq_valid_i && (enq_qid_i == QID_W'(q)) && !q_full[q];
    assign pop[q]  = serve && (sel == QID_W'(q));

    jwedf_fifo #(.DEPTH(DEPTH)) u_fifo (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .push_i  (push[q]),
      .din_i   (enq_entry),
      .pop_i   (pop[q]),
      .head_o  (head[q]),
      .nempty_o(q_nempty[q]),
      .full_o  (q_full[q])
    );

    assign head_dl[q]    = head[q].deadline;
    assign head_delay[q] = now_q - head[q].entry;

    jwedf_jitter u_jitter (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .upd_i    (pop[q]),
      .delay_i  (head_delay[q]),
      .jit_o    (jit_val[q]),
      .jit_nxt_o(jit_nxt[q])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      deq_gnt_o      <= 1'b0;
      deq_qid_o      <= '0;
      deq_desc_o     <= '0;
      deq_len_o      <= '0;
      deq_deadline_o <= '0;
      deq_delay_o    <= '0;
      deq_jitter_o   <= '0;
      enq_drop_o     <= 1'b0;
    end else begin
      deq_gnt_o  <= serve;
      enq_drop_o <= enq_valid_i && q_full[enq_qid_i];
      if (serve) begin
        deq_qid_o      <= sel;
        deq_desc_o     <= head[sel].desc;
        deq_len_o      <= head[sel].len;
        deq_deadline_o <= head[sel].deadline;
        deq_delay_o    <= head_delay[sel];
        deq_jitter_o   <= jit_nxt[sel];
      end
    end
  end
endmodule

// File: rtl/jwedf_checker.sv
module jwedf_checker import jwedf_pkg::*; #(
  parameter int NUM_Q = 4
) (
  input logic                         clk_i,
  input logic                         rst_ni,
  input logic                         deq_req_i,
  input logic                         deq_gnt_o,
  input logic                         enq_valid_i,
  input logic                         enq_drop_o,
  input logic [TIME_W-1:0]            deq_deadline_o,
  input logic [NUM_Q-1:0]             q_nempty,
  input logic [NUM_Q-1:0][TIME_W-1:0] head_dl,
  input logic [NUM_Q-1:0][JIT_W-1:0]  jit_val
);
  logic [TIME_W-1:0] min_c, min_q;

  always_comb begin
    min_c = '1;
    for (int i = 0; i < NUM_Q; i++)
      if (q_nempty[i] && head_dl[i] < min_c) min_c = head_dl[i];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) min_q <= '1;
    else         min_q <= min_c;
  end

  a_r4_gnt_needs_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    deq_gnt_o |-> $past(deq_req_i));

  a_r9_work_conserving: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (deq_req_i && (|q_nempty)) |=> deq_gnt_o);

  a_r9_no_gnt_when_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (deq_req_i && !(|q_nempty)) |=> !deq_gnt_o);

  a_r3_drop_needs_enq: assert property (@(posedge clk_i) disable iff (!rst_ni)
    enq_drop_o |-> $past(enq_valid_i));

  a_r5_earliest_served: assert property (@(posedge clk_i) disable iff (!rst_ni)
    deq_gnt_o |-> (deq_deadline_o == min_q));

  for (genvar q = 0; q < NUM_Q; q++) begin : g_jit
    a_r8_jitter_nondecreasing: assert property (@(posedge clk_i) disable iff (!rst_ni)
      jit_val[q] >= $past(jit_val[q]));
  end
endmodule

bind jwedf_sched jwedf_checker #(.NUM_Q(NUM_Q)) i_jwedf_checker (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .deq_req_i     (deq_req_i),
  .deq_gnt_o     (deq_gnt_o),
  .enq_valid_i   (enq_valid_i),
  .enq_drop_o    (enq_drop_o),
  .deq_deadline_o(deq_deadline_o),
  .q_nempty      (q_nempty),
  .head_dl       (head_dl),
  .jit_val       (jit_val)
);

// File: tb/test_jwedf_sched.sv
module test_jwedf_sched;
  import jwedf_pkg::*;
  localparam int CLK_PERIOD = 10;
  localparam int NQ = 4;
  localparam int DP = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_we = 1'b0;
  logic [1:0] cfg_qid = '0;
  logic [SCALE_W-1:0] cfg_scale = '0;
  logic enq_valid = 1'b0;
  logic [1:0] enq_qid = '0;
  logic [LEN_W-1:0] enq_len = '0;
  logic [DESC_W-1:0] enq_desc = '0;
  logic enq_drop;
  logic deq_req = 1'b0;
  logic deq_gnt;
  logic [1:0] deq_qid;
  logic [DESC_W-1:0] deq_desc;
  logic [LEN_W-1:0] deq_len;
  logic [TIME_W-1:0] deq_deadline, deq_delay;
  logic [JIT_W-1:0] deq_jitter;

  always #(CLK_PERIOD/2) clk = ~clk;

  jwedf_sched i_jwedf_sched (
    .clk_i(clk), .rst_ni(rst_n),
    .cfg_we_i(cfg_we), .cfg_qid_i(cfg_qid), .cfg_scale_i(cfg_scale),
    .enq_valid_i(enq_valid), .enq_qid_i(enq_qid), .enq_len_i(enq_len),
    .enq_desc_i(enq_desc), .enq_drop_o(enq_drop),
    .deq_req_i(deq_req), .deq_gnt_o(deq_gnt), .deq_qid_o(deq_qid),
    .deq_desc_o(deq_desc), .deq_len_o(deq_len), .deq_deadline_o(deq_deadline),
    .deq_delay_o(deq_delay), .deq_jitter_o(deq_jitter)
  );

  // time reference: edges since reset release
  longint cyc;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) cyc <= 0; else cyc <= cyc + 1;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  int     m_desc [NQ][DP];
  int     m_len  [NQ][DP];
  longint m_ent  [NQ][DP];
  longint m_dl   [NQ][DP];
  int     m_hd [NQ];
  int     m_cnt [NQ];
  longint m_scale [NQ];
  longint m_jit [NQ];
  longint m_last [NQ];
  bit     m_seen [NQ];
  longint JMAX = (64'd1 << JIT_W) - 1;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int q = 0; q < NQ; q++) begin
      m_hd[q] = 0; m_cnt[q] = 0; m_scale[q] = 65536;
      m_jit[q] = 0; m_last[q] = 0; m_seen[q] = 1'b0;
    end
  endtask

  task automatic cfg(input int q, input longint s);
    @(negedge clk);
    cfg_we = 1'b1; cfg_qid = 2'(q); cfg_scale = SCALE_W'(s);
    @(posedge clk); #1;
    cfg_we = 1'b0;
    m_scale[q] = s;
  endtask

  // one cycle: optional enqueue and optional request, then check outputs
  task automatic op(input bit ev, input int q, input int len, input int desc, input bit rq);
    bit e_gnt, e_drop;
    int best, nmin, e_desc, e_len;
    longint bdl, bj, e_dl, e_delay, e_jit, d;
    string tag;
    @(negedge clk);
    enq_valid = ev; enq_qid = 2'(q); enq_len = LEN_W'(len);
    enq_desc = DESC_W'(desc); deq_req = rq;
    e_gnt = 1'b0; best = -1; bdl = 0; bj = 0; tag = "R5";
    e_desc = 0; e_len = 0; e_dl = 0; e_delay = 0; e_jit = 0;
    e_drop = ev && (m_cnt[q] == DP);
    if (rq) begin
      for (int i = 0; i < NQ; i++) if (m_cnt[i] > 0) begin
        longint dl = m_dl[i][m_hd[i]];
        if (best < 0 || dl < bdl || (dl == bdl && m_jit[i] > bj)) begin
          best = i; bdl = dl; bj = m_jit[i];
        end
      end
      if (best >= 0) begin
        nmin = 0;
        for (int i = 0; i < NQ; i++)
          if (m_cnt[i] > 0 && m_dl[i][m_hd[i]] == bdl) nmin++;
        if (nmin > 1) begin
          int njm = 0;
          for (int i = 0; i < NQ; i++)
            if (m_cnt[i] > 0 && m_dl[i][m_hd[i]] == bdl && m_jit[i] == bj) njm++;
          tag = (njm > 1) ? "R7" : "R6";
        end
        e_gnt = 1'b1;
        e_desc = m_desc[best][m_hd[best]];
        e_len = m_len[best][m_hd[best]];
        e_dl = bdl;
        e_delay = cyc - m_ent[best][m_hd[best]];
        if (m_seen[best]) begin
          d = (e_delay >= m_last[best]) ? e_delay - m_last[best] : m_last[best] - e_delay;
          m_jit[best] = (m_jit[best] + d > JMAX) ? JMAX : m_jit[best] + d;
        end
        m_seen[best] = 1'b1; m_last[best] = e_delay;
        e_jit = m_jit[best];
        m_hd[best] = (m_hd[best] + 1) % DP; m_cnt[best]--;
      end
    end
    if (ev && !e_drop) begin
      int w = (m_hd[q] + m_cnt[q]) % DP;
      m_desc[q][w] = desc; m_len[q][w] = len; m_ent[q][w] = cyc;
      m_dl[q][w] = cyc + ((longint'(len) * m_scale[q]) >> 16);
      m_cnt[q]++;
    end
    @(posedge clk); #1;
    enq_valid = 1'b0; deq_req = 1'b0;
    if (ev) chk(enq_drop == e_drop, "R3", "drop strobe", enq_drop, e_drop);
    if (rq) begin
      chk(deq_gnt == e_gnt, "R9", "grant", deq_gnt, e_gnt);
      if (e_gnt && deq_gnt) begin
        chk(deq_qid == 2'(best), tag, "queue", deq_qid, best);
        chk(deq_desc == DESC_W'(e_desc), "R3", "descriptor", deq_desc, e_desc);
        chk(deq_len == LEN_W'(e_len), "R4", "length", deq_len, e_len);
        chk(deq_deadline == TIME_W'(e_dl), "R2", "deadline", deq_deadline, e_dl);
        chk(deq_delay == TIME_W'(e_delay), "R4", "delay", deq_delay, e_delay);
        chk(deq_jitter == JIT_W'(e_jit), "R8", "jitter", deq_jitter, e_jit);
      end
    end
  endtask

  task automatic drain();
    int tot = 0;
    for (int q = 0; q < NQ; q++) tot += m_cnt[q];
    for (int k = 0; k < tot; k++) op(1'b0, 0, 0, 0, 1'b1);
  endtask

  initial begin
    model_reset();
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk(deq_gnt == 1'b0, "R1", "grant after reset", deq_gnt, 0);
    chk(enq_drop == 1'b0, "R1", "drop after reset", enq_drop, 0);
    op(1'b0, 0, 0, 0, 1'b1);   // R1/R9: empty request, no grant

    // R3/R4: FIFO order on one queue, default scale (R1: 1.0)
    for (int k = 0; k < 6; k++) op(1'b1, 1, k * 3, 10 + k, 1'b0);
    for (int k = 0; k < 6; k++) op(1'b0, 0, 0, 0, 1'b1);

    // R10: scale change affects later enqueues only
    op(1'b1, 0, 40, 1, 1'b0);
    cfg(0, 3 * 65536);
    op(1'b1, 0, 40, 2, 1'b0);
    drain();

    // R5/R2: sweep of lengths over four queues with distinct scales
    cfg(0, 65536); cfg(1, 2 * 65536); cfg(2, 32768); cfg(3, 3 * 65536);
    for (int a = 0; a < 3; a++) for (int b = 0; b < 3; b++)
      for (int c = 0; c < 3; c++) for (int e = 0; e < 3; e++) begin
        op(1'b1, 0, a * 5, 1, 1'b0);
        op(1'b1, 1, b * 5, 2, 1'b0);
        op(1'b1, 2, c * 5, 3, 1'b0);
        op(1'b1, 3, e * 5, 4, 1'b0);
        drain();
      end

    // R3/R11: fill queue 2, overflow, overflow during its own pop
    for (int k = 0; k < DP + 1; k++) op(1'b1, 2, 1, 100 + k, 1'b0);
    op(1'b1, 2, 1, 200, 1'b1);
    op(1'b1, 2, 1, 201, 1'b0);
    drain();

    // R11: enqueue with request on empty block gives no grant
    op(1'b1, 3, 0, 77, 1'b1);
    op(1'b1, 3, 0, 78, 1'b1);
    drain();

    // R6/R8: give queue 3 jitter, then tie it with queue 0
    for (int q = 0; q < NQ; q++) cfg(q, 65536);
    op(1'b1, 3, 0, 5, 1'b0);
    op(1'b0, 0, 0, 0, 1'b1);
    op(1'b1, 3, 0, 6, 1'b0);
    repeat (6) @(posedge clk);
    op(1'b0, 0, 0, 0, 1'b1);
    op(1'b1, 0, 2, 7, 1'b0);
    op(1'b1, 3, 1, 8, 1'b0);
    op(1'b0, 0, 0, 0, 1'b1);
    op(1'b0, 0, 0, 0, 1'b1);
    // R7: fresh-equal tie on queues 1 and 2 after equalizing via reset
    @(negedge clk); rst_n = 1'b0; model_reset();
    @(negedge clk); rst_n = 1'b1;
    op(1'b1, 2, 2, 9, 1'b0);
    op(1'b1, 1, 1, 10, 1'b0);
    op(1'b0, 0, 0, 0, 1'b1);
    op(1'b0, 0, 0, 0, 1'b1);

    // mixed traffic with frequent ties and collisions
    for (int k = 0; k < 4000; k++)
      op($urandom_range(0, 9) < 6, $urandom_range(0, 3), $urandom_range(0, 3),
         $urandom_range(0, 255), $urandom_range(0, 1) == 1);
    drain();
    for (int q = 0; q < NQ; q++) cfg(q, $urandom_range(16384, 4 * 65536));
    for (int k = 0; k < 3000; k++)
      op($urandom_range(0, 9) < 6, $urandom_range(0, 3), $urandom_range(0, 40),
         $urandom_range(0, 255), $urandom_range(0, 1) == 1);
    drain();
    op(1'b0, 0, 0, 0, 1'b1);
    done = 1'b1;
  end

  initial begin
    fork
      begin repeat (200000) @(posedge clk);
        if (!done) chk(1'b0, "R9", "watchdog expired", 0, 1);
      end
      wait (done);
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule